// File: doc/BRIEF.md
# Set/Clear Aliased Flag Register

This block holds a bank of event flags that software reaches over a simple synchronous register bus. Each flag can be raised or lowered on its own with a single bus write. A ones-mask written to a write-only raise alias sets the chosen flags, and a ones-mask written to a write-only lower alias clears them. Concurrent software agents can therefore change different flags without a read-modify-write sequence and without locking each other out.

The flags are readable at their own address, which is read-only. They are also driven out continuously to application logic. Application logic can raise flags through a per-bit hardware set input. When a hardware set and a bus clear hit the same bit in the same cycle, the set takes effect. Read data is registered and is returned one cycle after the read strobe.

Top module: `scaf_flag_reg`

## Requirements
- R1: On a synchronous active-high reset, all flags and the read data become 0x00.
- R2: A write to offset 1 (raise alias) sets every flag whose bit is 1 in the write data, and leaves flags whose bit is 0 unchanged. Writing 0x04 changes bit 2 alone.
- R3: A write to offset 2 (lower alias) clears every flag whose bit is 1 in the write data, and leaves flags whose bit is 0 unchanged.
- R4: A write to offset 0 (flag view) or to offset 3 (unmapped) leaves all flags unchanged.
- R5: A read strobe at offset 0 returns the flags on the read data in the cycle after the strobe. The value returned is the one held before any update made in the same cycle.
- R6: A read strobe at offset 1, 2 or 3 returns 0x00 in the cycle after the strobe.
- R7: A 1 on a bit of the hardware set input sets that flag at the next clock edge. This holds even when a lower-alias write clears the same bit in the same cycle.
- R8: The flag output shows the flag state, which is updated at the clock edge that samples the write or the hardware set.
- R9: In the cycle after a cycle with no read strobe, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (2) | Register offset: 0 flag view, 1 raise alias, 2 lower alias |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (8) | Write data, used as a per-bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (8) | Registered read data |
| hw_set | input | DATA_W (8) | Per-bit hardware set events |
| flags_out | output | DATA_W (8) | Current flags, sent to application logic |

## Verification
A flag change from a bus write or a hardware set is registered at the edge that samples it. The bench therefore compares the flag output against its model shortly after that same edge. Read data is due one edge after the read strobe is sampled. The driver queues the expected byte for each read, taken from the model before that cycle's update. The monitor uses its own one-cycle-delayed copy of the strobe to pop and compare the queued byte at the following falling edge. In cycles with no read, it checks that the read data is zero.

// File: rtl/scaf_pkg.sv
package scaf_pkg;
  localparam int OFF_FLAGS = 0;
  localparam int OFF_RAISE = 1;
  localparam int OFF_LOWER = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_RAISE = 2'd1,
    ACC_LOWER = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/scaf_decode.sv
module scaf_decode
  import scaf_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output wr_kind_e          wr_kind,
  output logic              rd_flags
);
  always_comb begin
    wr_kind = ACC_NONE;
    if (wr) begin
      if (addr == ADDR_W'(OFF_RAISE))      wr_kind = ACC_RAISE;
      else if (addr == ADDR_W'(OFF_LOWER)) wr_kind = ACC_LOWER;
    end
  end

  assign rd_flags = rd && (addr == ADDR_W'(OFF_FLAGS));
endmodule

// File: rtl/scaf_flag_bank.sv
module scaf_flag_bank
  import scaf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_kind_e          wr_kind,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] flags
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic raise_b, lower_b;
    assign raise_b = hw_set[b] || ((wr_kind == ACC_RAISE) && mask[b]);
    assign lower_b = (wr_kind == ACC_LOWER) && mask[b];
    always_ff @(posedge clk) begin
      if (rst)          flags[b] <= 1'b0;
      else if (raise_b) flags[b] <= 1'b1;
      else if (lower_b) flags[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/scaf_read_port.sv
module scaf_read_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_flags,
  input  logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (rd_flags) rdata <= flags;
    else               rdata <= '0;
  end
endmodule

// File: rtl/scaf_flag_reg.sv
module scaf_flag_reg
  import scaf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] flags_out
);
  wr_kind_e          wr_kind;
  logic              rd_flags;
  logic [DATA_W-1:0] flags;

  scaf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_kind(wr_kind), .rd_flags(rd_flags)
  );

  scaf_flag_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_kind(wr_kind), .mask(bus_wdata),
    .hw_set(hw_set), .flags(flags)
  );

  scaf_read_port #(.DATA_W(DATA_W)) u_rport (
    .clk(clk), .rst(rst), .rd_flags(rd_flags), .flags(flags),
    .rdata(bus_rdata)
  );

  assign flags_out = flags;
endmodule

// File: rtl/scaf_flag_reg_chk.sv
module scaf_flag_reg_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] hw_set,
  input logic [DATA_W-1:0] flags_out
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flags_out == '0) && (bus_rdata == '0));

  a_r2_raise: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1)) |=>
      ((flags_out & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_lower: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(2)) |=>
      ((flags_out & $past(bus_wdata & ~hw_set)) == '0));

  a_r4_view_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != ADDR_W'(1) && bus_addr != ADDR_W'(2) && hw_set == '0)
      |=> $stable(flags_out));

  a_r5_read_flags: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(0)) |=> (bus_rdata == $past(flags_out)));

  a_r6_read_alias_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != ADDR_W'(0)) |=> (bus_rdata == '0));

  a_r7_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((flags_out & $past(hw_set)) == $past(hw_set)));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind scaf_flag_reg scaf_flag_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .hw_set(hw_set), .flags_out(flags_out)
);

// File: tb/scaf_flag_reg_bench.sv
`timescale 1ns/1ps
module scaf_flag_reg_bench;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] hw_set = '0;
  logic [DW-1:0] flags_out;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] model = '0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;
  logic          live = 1'b0;

  always #5 clk = ~clk;

  scaf_flag_reg #(.DATA_W(DW), .ADDR_W(AW)) u_scaf_flag_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_set(hw_set), .flags_out(flags_out)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, model update, queue expected read data
  task automatic cyc(logic wr, logic rd, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic [DW-1:0] hw, string tag);
    logic [DW-1:0] nxt;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; hw_set = hw;
    if (rd) begin
      exp_q.push_back((a == 0) ? model : 8'h00);
      tag_q.push_back(tag);
    end
    nxt = model;
    if (wr && a == 1) nxt = nxt | d;
    if (wr && a == 2) nxt = nxt & ~d;
    nxt = nxt | hw;
    model = nxt;
    @(posedge clk);
    #1;
    check({tag, " flags_out"}, flags_out, model);
    bus_wr = 1'b0; bus_rd = 1'b0; hw_set = '0;
  endtask

  // monitor
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (live) begin
      if (rd_seen) begin
        if (exp_q.size() == 0) check("R5 unexpected read", bus_rdata, 8'hxx);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end else begin
        check("R9 idle rdata", bus_rdata, 8'h00);
      end
    end
  end

  initial begin
    #(20000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 reset flags", flags_out, 8'h00);
    check("R1 reset rdata", bus_rdata, 8'h00);
    live = 1'b1;
    cyc(0, 1, 0, 0, 0, "R5 read after reset");
    cyc(1, 0, 1, 8'h04, 0, "R2 raise bit2 only");
    cyc(0, 1, 0, 0, 0, "R5 read 0x04");
    cyc(1, 0, 1, 8'hA1, 0, "R2 raise mask A1");
    cyc(1, 0, 1, 8'h00, 0, "R2 raise zero mask");
    cyc(0, 1, 0, 0, 0, "R5 read 0xA5");
    cyc(1, 0, 2, 8'h81, 0, "R3 lower mask 81");
    cyc(1, 0, 2, 8'h00, 0, "R3 lower zero mask");
    cyc(0, 1, 0, 0, 0, "R5 read 0x24");
    cyc(1, 0, 0, 8'hFF, 0, "R4 write view ignored");
    cyc(1, 0, 3, 8'hFF, 0, "R4 write unmapped ignored");
    cyc(0, 1, 1, 0, 0, "R6 read raise alias");
    cyc(0, 1, 2, 0, 0, "R6 read lower alias");
    cyc(0, 1, 3, 0, 0, "R6 read unmapped");
    cyc(0, 0, 0, 0, 8'h10, "R7 hw set bit4");
    cyc(1, 0, 2, 8'h34, 8'h04, "R7 hw set beats lower");
    cyc(0, 1, 0, 0, 0, "R8 read after mix");
    cyc(1, 1, 0, 0, 0, "R5 read with view write");
    cyc(1, 1, 1, 8'hFF, 0, "R6 read alias during raise");
    cyc(1, 1, 2, 8'h0F, 0, "R6 read alias during lower");
    cyc(0, 1, 0, 0, 0, "R5 read 0xF0");
    cyc(0, 0, 0, 0, 0, "R9 idle");
    cyc(0, 0, 0, 0, 0, "R9 idle2");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    model = '0;
    check("R1 reset again flags", flags_out, 8'h00);
    live = 1'b0;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule